// File: doc/BRIEF.md
# Decimal Indexed Address Generator

This block turns a six-digit packed-BCD address field into an absolute decimal address. The top digit of the field is a control digit. Its upper bit pair picks one of three signed index registers, or none. Its lower bit pair gives a data-format code, and for three of the four codes it also gives the top decimal digit of the field value. The five lower digits are a base-relative offset. The block adds the field value and the base register digit by digit. When an index is selected, it then adds or subtracts the index magnitude in a second digit-serial pass. Subtraction is done by adding the ten's complement.

A caller holds the operands steady and pulses `start` while the block is idle. The block then steps through its states. It pulses `done` for one cycle when the absolute address, the format code, the indirect flag and the error flag are ready. These results stay on the outputs until the next accepted start. The states are S_IDLE, S_BASE, S_INDEX and S_DONE. The transitions are:
- S_IDLE to S_BASE on a start with valid digits.
- S_IDLE to S_DONE on a start with a bad digit.
- S_BASE to S_INDEX after seven digit steps when an index is selected.
- S_BASE to S_DONE after seven digit steps when no index is selected.
- S_INDEX to S_DONE after seven digit steps.
- S_DONE to S_IDLE always.

Top module: `dec_addr_gen`

## Requirements
- R1: Field bits [23:22] select the index: 00 none, 01 `ix1`, 10 `ix2`, 11 `ix3`. The selected index value is added to the sum.
- R2: Field bits [21:20] appear on `fmt` (00 unsigned, 01 signed, 10 eight-bit character, 11 indirect). `indirect` is 1 exactly when they are 11.
- R3: The field value has the bits [21:20] value as its top decimal digit when that value is 0 to 2, and 0 when it is 3. Its lower five digits are field bits [19:0]. With no index selected, the absolute address equals the field value plus `base`, with decimal carries.
- R4: Index ports are bit 24 for the sign (1 = negative) and bits [23:0] for six BCD digits. A negative index is subtracted.
- R5: `addr_err` is 1 when any offset digit, any `base` digit, or any digit of the selected index exceeds 9. Digits of unselected index registers are ignored.
- R6: `addr_err` is 1 when the result is below 0 or above 299999. Otherwise `abs_addr` holds the six BCD digits of the result.
- R7: `done` is a one-cycle pulse. Count the rising edge that accepts `start` as edge 1. `done` is high after edge 8 with no index, after edge 15 with an index, and after edge 1 on a digit error. `busy` is high during the digit steps.
- R8: A `start` that arrives while the block is not idle is ignored. The outputs hold their values after `done` until the next accepted start.
- R9: After reset, `done`, `busy`, `addr_err` and `abs_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| field | input | 24 | Control digit and five-digit BCD offset |
| base | input | 24 | Base register, six BCD digits |
| ix1 | input | 25 | Index register 1, sign and six BCD digits |
| ix2 | input | 25 | Index register 2, sign and six BCD digits |
| ix3 | input | 25 | Index register 3, sign and six BCD digits |
| busy | output | 1 | Digit steps in progress |
| done | output | 1 | One-cycle result-ready pulse |
| abs_addr | output | 24 | Absolute address, six BCD digits |
| fmt | output | 2 | Data-format code |
| indirect | output | 1 | Format code is indirect |
| addr_err | output | 1 | Bad digit or out-of-range result |

## Verification
A corrupted step counter or state register shows up first at the ports as a wrong `done` latency. The bench measures that latency for every conversion, so such a fault is seen on the first conversion. A wrong carry or complement state shows up as one misplaced digit in `abs_addr` or a wrong `addr_err` in the `done` cycle. The vectors cover decimal carry chains, borrows below zero and the 299999 limit, so these faults show within a few conversions. A format register that changes while the block is busy is visible on `fmt` at `done`.

// File: rtl/dag_pkg.sv
package dag_pkg;
    localparam int DIG_W = 4;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BASE  = 2'd1,
        S_INDEX = 2'd2,
        S_DONE  = 2'd3
    } dag_state_t;
endpackage

// File: rtl/dag_digit_adder.sv
module dag_digit_adder (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       cin,
    output logic [3:0] sum,
    output logic       cout
);
    logic [4:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b} + {4'd0, cin};
        if (raw > 5'd9) begin
            sum  = 4'(raw + 5'd6);
            cout = 1'b1;
        end else begin
            sum  = raw[3:0];
            cout = 1'b0;
        end
    end

    // R3: decimal digits in give a decimal digit out
    always_comb begin
        if (a <= 4'd9 && b <= 4'd9)
            p_digit_sum_r3: assert (sum <= 4'd9);
    end
endmodule

// File: rtl/dag_range_check.sv
module dag_range_check #(
    parameter int ND = 6
) (
    input  logic [4*ND-1:0] digits,
    output logic            bad
);
    logic [ND-1:0] over;

    generate
        for (genvar g = 0; g < ND; g++) begin : g_dig
            assign over[g] = digits[4*g +: 4] > 4'd9;
        end
    endgenerate

    assign bad = |over;
endmodule

// File: rtl/dec_addr_gen.sv
module dec_addr_gen #(
    parameter int NDIG    = 6,
    parameter int MAX_TOP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [4*NDIG-1:0]   field,
    input  logic [4*NDIG-1:0]   base,
    input  logic [4*NDIG:0]     ix1,
    input  logic [4*NDIG:0]     ix2,
    input  logic [4*NDIG:0]     ix3,
    output logic                busy,
    output logic                done,
    output logic [4*NDIG-1:0]   abs_addr,
    output logic [1:0]          fmt,
    output logic                indirect,
    output logic                addr_err
);
    import dag_pkg::*;

    localparam int W  = 4 * NDIG;
    localparam int AW = 4 * (NDIG + 1);
    localparam int OW = 4 * (NDIG - 1);
    localparam int CW = $clog2(NDIG + 1);

    dag_state_t       state;
    logic [CW-1:0]    cnt;
    logic [AW-1:0]    opa, opb, ixop_q;
    logic             carry, neg_q, has_ix, derr_q;
    logic [1:0]       fmt_q;

    // operand decode
    logic [1:0]    sel_c, ctrl_c;
    logic [3:0]    hi_c;
    logic [AW-1:0] fval_c, ixop_c;
    logic [W:0]    ix_c;
    logic          off_bad, base_bad, ix_bad, err_in;

    always_comb begin
        sel_c  = field[W-1:W-2];
        ctrl_c = field[W-3:W-4];
        hi_c   = (ctrl_c == 2'b11) ? 4'd0 : {2'b00, ctrl_c};
        fval_c = {4'd0, hi_c, field[OW-1:0]};
        unique case (sel_c)
            2'b01:   ix_c = ix1;
            2'b10:   ix_c = ix2;
            2'b11:   ix_c = ix3;
            default: ix_c = '0;
        endcase
        for (int i = 0; i < NDIG; i++)
            ixop_c[4*i +: 4] = ix_c[W] ? 4'd9 - ix_c[4*i +: 4] : ix_c[4*i +: 4];
        ixop_c[AW-1:AW-4] = ix_c[W] ? 4'd9 : 4'd0;
    end

    dag_range_check #(.ND(NDIG - 1)) u_chk_off  (.digits(field[OW-1:0]), .bad(off_bad));
    dag_range_check #(.ND(NDIG))     u_chk_base (.digits(base),          .bad(base_bad));
    dag_range_check #(.ND(NDIG))     u_chk_ix   (.digits(ix_c[W-1:0]),   .bad(ix_bad));

    assign err_in = off_bad | base_bad | ((sel_c != 2'b00) & ix_bad);

    // digit-serial decimal adder
    logic [3:0] dsum;
    logic       dcout;

    dag_digit_adder u_add (
        .a(opa[3:0]), .b(opb[3:0]), .cin(carry), .sum(dsum), .cout(dcout)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            opa    <= '0;
            opb    <= '0;
            ixop_q <= '0;
            carry  <= 1'b0;
            neg_q  <= 1'b0;
            has_ix <= 1'b0;
            derr_q <= 1'b0;
            fmt_q  <= 2'b00;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        opa    <= fval_c;
                        opb    <= {4'd0, base};
                        ixop_q <= ixop_c;
                        carry  <= 1'b0;
                        cnt    <= '0;
                        fmt_q  <= ctrl_c;
                        has_ix <= sel_c != 2'b00;
                        neg_q  <= (sel_c != 2'b00) & ix_c[W];
                        derr_q <= err_in;
                        state  <= err_in ? S_DONE : S_BASE;
                    end
                end
                S_BASE, S_INDEX: begin
                    opa   <= {dsum, opa[AW-1:4]};
                    opb   <= {4'd0, opb[AW-1:4]};
                    carry <= dcout;
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(NDIG)) begin
                        cnt <= '0;
                        if (state == S_BASE && has_ix) begin
                            opb   <= ixop_q;
                            carry <= neg_q;
                            state <= S_INDEX;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    logic range_bad;

    always_comb begin
        range_bad = (opa[AW-1:AW-4] != 4'd0) || (opa[W-1:W-4] > 4'(MAX_TOP));
        busy      = (state == S_BASE) || (state == S_INDEX);
        done      = (state == S_DONE);
        abs_addr  = opa[W-1:0];
        fmt       = fmt_q;
        indirect  = (fmt_q == 2'b11);
        addr_err  = derr_q | (neg_q & ~carry) | range_bad;
    end

    // assertions
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    p_fmt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fmt));
    p_err_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && err_in) |=> (done && addr_err));
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(NDIG));
endmodule

// File: tb/dec_addr_gen_bench.sv
`timescale 1ns/1ps
module dec_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] field = '0, base = '0;
    logic [24:0] ix1 = 25'h0000100, ix2 = 25'h1000050, ix3 = 25'h0100000;
    logic        busy, done, indirect, addr_err;
    logic [23:0] abs_addr;
    logic [1:0]  fmt;

    int checks = 0;
    int fails  = 0;
    int lat;

    always #10 clk = ~clk;

    dec_addr_gen u_dec_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .field(field), .base(base),
        .ix1(ix1), .ix2(ix2), .ix3(ix3), .busy(busy), .done(done),
        .abs_addr(abs_addr), .fmt(fmt), .indirect(indirect), .addr_err(addr_err)
    );

    typedef struct packed {
        logic [23:0] fld;
        logic [23:0] bse;
        logic [23:0] exp_abs;
        logic        exp_err;
        logic [1:0]  exp_fmt;
        logic [4:0]  exp_lat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{24'h012345, 24'h001000, 24'h013345, 1'b0, 2'd0, 5'd8 },
        '{24'h512345, 24'h001000, 24'h113445, 1'b0, 2'd1, 5'd15},
        '{24'hA00500, 24'h000000, 24'h200450, 1'b0, 2'd2, 5'd15},
        '{24'hF00010, 24'h000005, 24'h100015, 1'b0, 2'd3, 5'd15},
        '{24'h800020, 24'h000000, 24'h000000, 1'b1, 2'd0, 5'd15},
        '{24'h299999, 24'h000001, 24'h000000, 1'b1, 2'd2, 5'd8 },
        '{24'h299998, 24'h000001, 24'h299999, 1'b0, 2'd2, 5'd8 },
        '{24'h01A000, 24'h000000, 24'h000000, 1'b1, 2'd0, 5'd1 },
        '{24'h099999, 24'h000001, 24'h100000, 1'b0, 2'd0, 5'd8 },
        '{24'h000001, 24'h00B000, 24'h000000, 1'b1, 2'd0, 5'd1 }
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] f, input logic [23:0] b);
        @(negedge clk);
        field = f;
        base  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 done", {31'd0, done}, 32'd0);
        check("R9 busy", {31'd0, busy}, 32'd0);
        check("R9 addr_err", {31'd0, addr_err}, 32'd0);
        check("R9 abs_addr", {8'd0, abs_addr}, 32'd0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            run(VECS[v].fld, VECS[v].bse);
            check("R7 latency", lat, {27'd0, VECS[v].exp_lat});
            check("R5 R6 addr_err", {31'd0, addr_err}, {31'd0, VECS[v].exp_err});
            check("R2 fmt", {30'd0, fmt}, {30'd0, VECS[v].exp_fmt});
            check("R2 indirect", {31'd0, indirect}, {31'd0, VECS[v].exp_fmt == 2'd3});
            if (!VECS[v].exp_err)
                check("R1 R3 R4 abs_addr", {8'd0, abs_addr}, {8'd0, VECS[v].exp_abs});
            @(negedge clk);
            check("R7 done single pulse", {31'd0, done}, 32'd0);
        end

        // R5: a bad digit in an unselected index is ignored
        ix1 = 25'h00000A0;
        run(24'h000100, 24'h000000);
        check("R5 unselected bad index err", {31'd0, addr_err}, 32'd0);
        check("R5 unselected bad index abs", {8'd0, abs_addr}, 32'h000100);
        // R5: the same register selected gives an error
        run(24'h400100, 24'h000000);
        check("R5 selected bad index err", {31'd0, addr_err}, 32'd1);
        check("R5 selected bad index latency", lat, 32'd1);
        ix1 = 25'h0000100;

        // R4: negative zero index leaves the sum unchanged
        ix2 = 25'h1000000;
        run(24'h800777, 24'h000003);
        check("R4 negative zero abs", {8'd0, abs_addr}, 32'h000780);
        check("R4 negative zero err", {31'd0, addr_err}, 32'd0);
        ix2 = 25'h1000050;

        // R8: start while busy is ignored
        @(negedge clk);
        field = 24'h012345;
        base  = 24'h000000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy during steps", {31'd0, busy}, 32'd1);
        @(negedge clk);
        field = 24'h299999;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R8 busy start latency", lat, 32'd8);
        check("R8 busy start abs", {8'd0, abs_addr}, 32'h012345);
        check("R8 busy start fmt", {30'd0, fmt}, 32'd0);
        // R8: outputs hold after done
        field = 24'hF99999;
        base  = 24'h999999;
        repeat (5) @(negedge clk);
        check("R8 hold abs", {8'd0, abs_addr}, 32'h012345);
        check("R8 hold err", {31'd0, addr_err}, 32'd0);
        check("R8 hold busy", {31'd0, busy}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule